// File: doc/BRIEF.md
# Parallel Instruction Buffer FIFO

This block sits between a fast parallel host write port and a slower internal command consumer. Each host write carries one whole instruction: a channel address, a register select and a data word. In buffered mode, writes are queued so the host can issue a burst at full speed while the consumer drains the queue at its own pace. In pass-through mode there is no storage at all. The host sees the consumer's ready signal directly and is held off while the consumer is busy.

The choice between the two modes is made from an enable pin, and only at fixed moments: the first clock after reset is released, and each clear event. Between those moments the pin may move freely without effect. Buffering is allowed only when the parallel interface is selected. A clear empties the queue. A write that arrives while the queue is full is silently dropped.

Top module: `cmd_burst_buffer`

## Requirements
- R1: While `rstN` is low and in the cycle after it rises, `cmdValid` and `full` are 0, and the queue is empty.
- R2: The mode is latched as buffered exactly when `fifoEnPin` and `parallelSel` are both 1 at the first rising edge after `rstN` goes high, or at a rising edge with `clearReq` high. At any other edge, changes on these pins leave the mode unchanged.
- R3: In buffered mode, instructions reach the consumer in the order they were written. One instruction leaves per edge where `cmdValid` and `cmdReady` are both 1. The head stays stable while it is not taken.
- R4: The queue holds up to DEPTH (default 128) instructions. `full` is 1 exactly when DEPTH instructions are held in buffered mode.
- R5: A host write while `full` is 1 is discarded. The queued contents and their order are unchanged.
- R6: In buffered mode, `hostReady` is 1 whenever the queue is not full and no clear is requested. A write is stored whether or not the consumer is ready.
- R7: In pass-through mode, `cmdValid` equals `hostWr`, and the command fields equal the host fields in the same cycle. `hostReady` equals `cmdReady`.
- R8: A clear (`clearReq` high at an edge) discards all queued instructions. A write in that same cycle is not stored, and `cmdValid` is 0 during the clear cycle in buffered mode.
- R9: A write and a read at the same edge, with the queue neither full nor empty, keep the occupancy unchanged and preserve order.
- R10: `full` is 0 in pass-through mode, however many writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearReq | input | 1 | Clear event: empties the queue and re-latches the mode |
| fifoEnPin | input | 1 | Buffering enable level, active high |
| parallelSel | input | 1 | 1 when the parallel interface is the selected host interface |
| hostWr | input | 1 | Host write strobe |
| hostAddr | input | ADDR_W (5) | Instruction channel address |
| hostSel | input | SEL_W (2) | Instruction register select |
| hostData | input | DATA_W (14) | Instruction data |
| hostReady | output | 1 | A write in this cycle will be taken |
| full | output | 1 | Queue holds DEPTH instructions |
| cmdValid | output | 1 | An instruction is presented to the consumer |
| cmdReady | input | 1 | Consumer takes the presented instruction |
| cmdAddr | output | ADDR_W (5) | Presented channel address |
| cmdSel | output | SEL_W (2) | Presented register select |
| cmdData | output | DATA_W (14) | Presented data |

## Verification
The hardest state to reach is a full queue that then sees a further write. The consumer must stay stalled for DEPTH consecutive writes before the dropped write can be tried. The bench does this by holding `cmdReady` low through a 128-write burst, then writing once more. It then drains the whole queue and checks that the last instruction out is the 128th written and that nothing follows. Mode latching is checked by moving `fifoEnPin` between clears and observing that pass-through behaviour persists. A second, similar case is a clear with a write in the same cycle, where the write must not survive.

// File: rtl/cmd_burst_buffer_pkg.sv
package cmd_burst_buffer_pkg;
  parameter int ADDR_W = 5;
  parameter int SEL_W  = 2;
  parameter int DATA_W = 14;
  localparam int INSTR_W = ADDR_W + SEL_W + DATA_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] data;
  } instr_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic bypass;
  } ctrl_strb_t;
endpackage

// File: rtl/cmd_burst_buffer_ctrl.sv
module cmd_burst_buffer_ctrl
  import cmd_burst_buffer_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clearReq,
  input  logic       fifoEnPin,
  input  logic       parallelSel,
  input  logic       hostWr,
  input  logic       cmdReady,
  output logic       hostReady,
  output logic       cmdValid,
  output logic       full,
  output logic       bufMode,
  output ctrl_strb_t strb
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;
  logic             armed;
  logic             isFull;
  logic             isEmpty;

  assign isFull  = (count == CNT_W'(DEPTH));
  assign isEmpty = (count == '0);

  always_comb begin
    if (bufMode) begin
      cmdValid  = !isEmpty && !clearReq;
      hostReady = !isFull && !clearReq;
    end else begin
      cmdValid  = hostWr;
      hostReady = cmdReady;
    end
    strb.bypass = !bufMode;
    strb.flush  = clearReq;
    strb.push   = bufMode && hostWr && !isFull && !clearReq;
    strb.pop    = bufMode && cmdValid && cmdReady;
  end

  assign full = bufMode && isFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      bufMode <= 1'b0;
      armed   <= 1'b1;
    end else begin
      armed <= 1'b0;
      if (armed || clearReq) begin
        bufMode <= fifoEnPin && parallelSel;
      end
      if (clearReq) begin
        count <= '0;
      end else if (strb.push && !strb.pop) begin
        count <= count + 1'b1;
      end else if (strb.pop && !strb.push) begin
        count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmd_burst_buffer_dp.sv
module cmd_burst_buffer_dp
  import cmd_burst_buffer_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrl_strb_t strb,
  input  instr_t     hostInstr,
  output instr_t     cmdInstr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  instr_t           mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push) begin
      mem[wrPtr] <= hostInstr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  assign cmdInstr = strb.bypass ? hostInstr : mem[rdPtr];
endmodule

// File: rtl/cmd_burst_buffer.sv
module cmd_burst_buffer
  import cmd_burst_buffer_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearReq,
  input  logic              fifoEnPin,
  input  logic              parallelSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [SEL_W-1:0]  hostSel,
  input  logic [DATA_W-1:0] hostData,
  output logic              hostReady,
  output logic              full,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [SEL_W-1:0]  cmdSel,
  output logic [DATA_W-1:0] cmdData
);
  ctrl_strb_t strb;
  instr_t     hostInstr;
  instr_t     cmdInstr;
  logic       bufMode;

  assign hostInstr = '{addr: hostAddr, sel: hostSel, data: hostData};
  assign cmdAddr   = cmdInstr.addr;
  assign cmdSel    = cmdInstr.sel;
  assign cmdData   = cmdInstr.data;

  cmd_burst_buffer_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .fifoEnPin(fifoEnPin),
    .parallelSel(parallelSel), .hostWr(hostWr), .cmdReady(cmdReady),
    .hostReady(hostReady), .cmdValid(cmdValid), .full(full),
    .bufMode(bufMode), .strb(strb)
  );

  cmd_burst_buffer_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostInstr(hostInstr), .cmdInstr(cmdInstr)
  );
endmodule

// File: rtl/cmd_burst_buffer_chk.sv
module cmd_burst_buffer_chk
  import cmd_burst_buffer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              clearReq,
  input logic              hostWr,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [DATA_W-1:0] hostData,
  input logic              hostReady,
  input logic              full,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [SEL_W-1:0]  cmdSel,
  input logic [DATA_W-1:0] cmdData,
  input logic              bufMode
);
  p_reset_idle_r1: assert property (@(posedge clk) $rose(rstN) |-> !cmdValid && !full);

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!clearReq && $past(rstN)) |=> $stable(bufMode));

  p_head_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bufMode && cmdValid && !cmdReady && !clearReq) |=>
      $stable({cmdAddr, cmdSel, cmdData}));

  p_full_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (full && !(cmdValid && cmdReady) && !clearReq) |=> full);

  p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !hostReady);

  p_pass_through_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!bufMode && hostWr) |-> cmdValid && cmdData == hostData && cmdAddr == hostAddr);

  p_clear_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> !full);

  p_no_full_bypass_r10: assert property (@(posedge clk) disable iff (!rstN)
    !bufMode |-> !full);
endmodule

bind cmd_burst_buffer cmd_burst_buffer_chk u_chk (
  .clk(clk), .rstN(rstN), .clearReq(clearReq), .hostWr(hostWr),
  .hostAddr(hostAddr), .hostData(hostData), .hostReady(hostReady),
  .full(full), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdAddr(cmdAddr),
  .cmdSel(cmdSel), .cmdData(cmdData), .bufMode(bufMode)
);

// File: tb/cmd_burst_buffer_tb.sv
module cmd_burst_buffer_tb;
  import cmd_burst_buffer_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic clk = 1'b0;
  logic rstN, clearReq, fifoEnPin, parallelSel, hostWr, cmdReady;
  logic [INSTR_W-1:0] hostWord;
  logic hostReady, full, cmdValid;
  logic [ADDR_W-1:0] cmdAddr;
  logic [SEL_W-1:0]  cmdSel;
  logic [DATA_W-1:0] cmdData;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_burst_buffer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .fifoEnPin(fifoEnPin),
    .parallelSel(parallelSel), .hostWr(hostWr),
    .hostAddr(hostWord[INSTR_W-1 -: ADDR_W]),
    .hostSel(hostWord[DATA_W +: SEL_W]), .hostData(hostWord[DATA_W-1:0]),
    .hostReady(hostReady), .full(full), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdSel(cmdSel), .cmdData(cmdData)
  );

  function automatic logic [INSTR_W-1:0] mkWord(input int i);
    return INSTR_W'(i * 40503 + 12345);
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Set inputs at falling edge; outputs settle before the next rising edge
  task automatic setIn(input logic wr, input logic [INSTR_W-1:0] w, input logic rdy, input logic clr);
    @(negedge clk);
    hostWr = wr; hostWord = w; cmdReady = rdy; clearReq = clr;
    #1;
  endtask

  function automatic logic [INSTR_W-1:0] cmdWord();
    return {cmdAddr, cmdSel, cmdData};
  endfunction

  task automatic doReset(input logic en, input logic par);
    @(negedge clk);
    rstN = 1'b0; fifoEnPin = en; parallelSel = par;
    hostWr = 1'b0; cmdReady = 1'b0; clearReq = 1'b0; hostWord = '0;
    #1;
    check("R1", "valid in reset", longint'(cmdValid), 0);
    check("R1", "full in reset", longint'(full), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);  // latch edge has passed
    #1;
    check("R1", "valid after reset", longint'(cmdValid), 0);
  endtask

  task automatic doClear(input logic en, input logic par);
    @(negedge clk);
    fifoEnPin = en; parallelSel = par;
    setIn(1'b0, '0, 1'b0, 1'b1);
    setIn(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_order;
    doReset(1'b1, 1'b1);
    for (int i = 0; i < 5; i++) begin
      setIn(1'b1, mkWord(i), 1'b0, 1'b0);
      check("R6", "hostReady while not full", longint'(hostReady), 1);
    end
    setIn(1'b0, '0, 1'b0, 1'b0);
    check("R3", "head held", longint'(cmdWord()), longint'(mkWord(0)));
    // R9: simultaneous push and pop keeps order
    for (int i = 0; i < 3; i++) begin
      setIn(1'b1, mkWord(5 + i), 1'b1, 1'b0);
      check("R9", "head during push+pop", longint'(cmdWord()), longint'(mkWord(i)));
    end
    for (int i = 3; i < 8; i++) begin
      setIn(1'b0, '0, 1'b1, 1'b0);
      check("R3", "valid in drain", longint'(cmdValid), 1);
      check("R3", "drain order", longint'(cmdWord()), longint'(mkWord(i)));
    end
    setIn(1'b0, '0, 1'b1, 1'b0);
    check("R9", "empty after drain", longint'(cmdValid), 0);
  endtask

  task automatic t_full;
    doReset(1'b1, 1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      setIn(1'b1, mkWord(100 + i), 1'b0, 1'b0);
      if (i == DEPTH - 1) check("R4", "full one short", longint'(full), 0);
    end
    setIn(1'b1, mkWord(999), 1'b0, 1'b0);
    check("R4", "full at depth", longint'(full), 1);
    check("R6", "hostReady when full", longint'(hostReady), 0);
    for (int i = 0; i < DEPTH; i++) begin
      setIn(1'b0, '0, 1'b1, 1'b0);
      if (cmdWord() != mkWord(100 + i) || !cmdValid)
        check("R5", "drain after drop", longint'(cmdWord()), longint'(mkWord(100 + i)));
      else checks++;
    end
    setIn(1'b0, '0, 1'b1, 1'b0);
    check("R5", "dropped write absent", longint'(cmdValid), 0);
  endtask

  task automatic t_clear;
    doReset(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) setIn(1'b1, mkWord(200 + i), 1'b0, 1'b0);
    setIn(1'b1, mkWord(250), 1'b0, 1'b1);
    check("R8", "valid during clear", longint'(cmdValid), 0);
    setIn(1'b0, '0, 1'b1, 1'b0);
    check("R8", "empty after clear", longint'(cmdValid), 0);
    check("R8", "full after clear", longint'(full), 0);
    setIn(1'b1, mkWord(260), 1'b0, 1'b0);
    setIn(1'b0, '0, 1'b0, 1'b0);
    check("R8", "still buffered after clear", longint'(cmdWord()), longint'(mkWord(260)));
  endtask

  task automatic t_mode;
    doReset(1'b1, 1'b1);
    doClear(1'b0, 1'b1);
    fifoEnPin = 1'b1;  // moved with no clear: must have no effect
    setIn(1'b1, mkWord(300), 1'b0, 1'b0);
    check("R7", "pass valid", longint'(cmdValid), 1);
    check("R7", "pass data", longint'(cmdWord()), longint'(mkWord(300)));
    check("R7", "ready follows consumer", longint'(hostReady), 0);
    setIn(1'b1, mkWord(301), 1'b1, 1'b0);
    check("R7", "ready follows consumer hi", longint'(hostReady), 1);
    setIn(1'b0, '0, 1'b0, 1'b0);
    check("R2", "pin change ignored", longint'(cmdValid), 0);
    for (int i = 0; i < DEPTH + 2; i++) setIn(1'b1, mkWord(i), 1'b1, 1'b0);
    check("R10", "no full in pass mode", longint'(full), 0);
    doClear(1'b1, 1'b0);
    setIn(1'b1, mkWord(310), 1'b0, 1'b0);
    setIn(1'b0, '0, 1'b0, 1'b0);
    check("R2", "serial forces pass", longint'(cmdValid), 0);
    doClear(1'b1, 1'b1);
    setIn(1'b1, mkWord(320), 1'b0, 1'b0);
    setIn(1'b0, '0, 1'b0, 1'b0);
    check("R2", "clear relatches buffered", longint'(cmdWord()), longint'(mkWord(320)));
  endtask

  initial begin
    rstN = 1'b0; clearReq = 1'b0; fifoEnPin = 1'b0; parallelSel = 1'b0;
    hostWr = 1'b0; cmdReady = 1'b0; hostWord = '0;
    t_order();
    t_full();
    t_clear();
    t_mode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule